// File: doc/BRIEF.md
# Erasable Programmable Memory Device Model

This block is a synthesizable, clock-driven stand-in for a 2048-word by 8-bit UV-erasable programmable memory. It serves as the device under control in testbenches for programmer and reader logic. Analog levels and supply ordering are not modelled. The two supply conditions that change behaviour are single-bit flags. One flag says the high programming voltage is present. The other says the programming pin is tied to ground rather than to the logic-high level. The bidirectional data bus is split into a data input, a data output and a drive-enable output.

A single strobe acts both as chip enable and as program pulse. Low enables reads. High means standby, or a program pulse while the high voltage is present. A program operation can only pull bits from 1 to 0, so a word can never be set back to 1 by programming. A separate erase input, and reset, restore every word to all ones in one clock edge. Pulse length is measured in clock edges. A pulse that is too short or too long writes nothing and raises a sticky error flag. Read access time is modelled as a fixed number of clock edges before the output is marked valid.

Top module: `eprom_model`

## Requirements
- R1: The array has 2^ADDR_W words of DATA_W bits, selected by `addr`. Every word reads 8'hFF after the array has been wiped. A wipe happens at any clock edge where `erase` is 1 or `rst_n` is 0.
- R2: A successful program operation stores old AND `din` into the addressed word. Bits that are already 0 stay 0.
- R3: With `vpp_prog`=0 and `en_strobe`=1 the device is in standby. `dq_oe`=0 and `dvalid`=0, whatever `out_en` is.
- R4: With `vpp_prog`=0 and `en_strobe`=0, the device drives (`dq_oe`=1) only when `out_en` is at its active level. Otherwise the outputs float. The active level is 0 when `vpp_gnd`=0 and 1 when `vpp_gnd`=1.
- R5: Program pulse, with `vpp_prog`=1 and `out_en`=1. A pulse begins at a clock edge that samples `en_strobe`=1 after a sample of 0. At that edge `addr` and `din` are captured. Pulse length is the number of edges that sample `en_strobe`=1. The word is written at the first edge that samples `en_strobe`=0, if PULSE_MIN <= length <= PULSE_MAX.
- R6: With `vpp_prog`=1, `en_strobe`=0 and `out_en`=0, the device is in verify. It drives the stored word, with the same latency as a read.
- R7: With `vpp_prog`=1, `en_strobe`=0 and `out_en`=1, the device is in inhibit: outputs float and no write occurs. A strobe rise while `out_en`=0 starts no pulse, even if `out_en` rises afterwards.
- R8: A pulse shorter than PULSE_MIN writes nothing and sets `pulse_err`.
- R9: A pulse longer than PULSE_MAX writes nothing. It sets `pulse_err` at the edge where its length exceeds PULSE_MAX. `pulse_err` stays set until reset.
- R10: `dvalid`=1 only while the device drives and ACC_CYC consecutive edges have sampled the same `addr` with the outputs driven. `dout` equals the addressed word when `dvalid`=1 and 0 otherwise.
- R11: A wipe and a pulse-ending write at the same edge leave the word all ones. A wipe also restarts the access count, so `dvalid` drops and returns after ACC_CYC further edges.
- R12: If `vpp_prog` or `out_en` falls while a pulse is open, the pulse is abandoned. Nothing is written and no error is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Active-low reset; also wipes the array |
| addr | input | ADDR_W | Word address |
| en_strobe | input | 1 | Chip enable (low) / program strobe (high) |
| out_en | input | 1 | Output enable, polarity per R4 |
| vpp_prog | input | 1 | High programming voltage present |
| vpp_gnd | input | 1 | Programming pin tied to ground during reads |
| erase | input | 1 | Whole-array erase to ones |
| din | input | DATA_W | Data bus as driven into the device |
| dout | output | DATA_W | Data bus as driven by the device |
| dq_oe | output | 1 | Device drives the data bus |
| dvalid | output | 1 | Output data has met its access latency |
| pulse_err | output | 1 | Sticky program pulse length violation |

## Verification
The two functions that can fall on one edge are the wipe and the clear-only write that closes a program pulse. The bench provokes this by driving `erase` high in the same cycle that `en_strobe` falls after a legal-length pulse. It then verifies that word, which must read all ones because the wipe has priority. The bench also wipes during a steady read and judges that `dvalid` drops for exactly ACC_CYC edges. A behavioural reference model is compared against every output on every clock.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

    typedef enum logic [2:0] {
        MD_READ,
        MD_ODIS,
        MD_STBY,
        MD_PROG,
        MD_VERIFY,
        MD_INHIBIT
    } mode_e;

endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
    import eprom_pkg::*;
(
    input  logic en_strobe,
    input  logic out_en,
    input  logic vpp_prog,
    input  logic vpp_gnd,
    output logic drive
);

    mode_e mode;
    logic  oe_active;

    always_comb begin
        oe_active = vpp_gnd ? out_en : !out_en;
        if (vpp_prog) begin
            if (en_strobe) mode = out_en ? MD_PROG : MD_INHIBIT;
            else           mode = out_en ? MD_INHIBIT : MD_VERIFY;
        end else if (en_strobe) begin
            mode = MD_STBY;
        end else begin
            mode = oe_active ? MD_READ : MD_ODIS;
        end
        drive = (mode == MD_READ) || (mode == MD_VERIFY);
    end

endmodule

// File: rtl/eprom_array.sv
module eprom_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wipe,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wipe) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (wr_en) begin
            mem[wr_addr] <= mem[wr_addr] & wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

    AST_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wipe) |=> ((mem[$past(wr_addr)] & ~$past(mem[wr_addr])) == '0)); // R2

    AST_WIPE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        wipe |=> ((&mem[0]) && (&mem[DEPTH-1]))); // R1

endmodule

// File: rtl/eprom_pulse.sv
module eprom_pulse #(
    parameter int ADDR_W    = 11,
    parameter int DATA_W    = 8,
    parameter int PULSE_MIN = 4,
    parameter int PULSE_MAX = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_strobe,
    input  logic              out_en,
    input  logic              vpp_prog,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              err
);

    localparam int            CW    = $clog2(PULSE_MAX + 2);
    localparam logic [CW-1:0] MIN_V = CW'(PULSE_MIN);
    localparam logic [CW-1:0] MAX_V = CW'(PULSE_MAX);

    typedef struct packed {
        logic              active;
        logic [CW-1:0]     cnt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              err;
        logic              strobe_prev;
    } pulse_t;

    pulse_t q, d;

    always_comb begin
        d             = q;
        wr_en         = 1'b0;
        d.strobe_prev = en_strobe;
        if (!q.active) begin
            if (vpp_prog && out_en && en_strobe && !q.strobe_prev) begin
                d.active = 1'b1;
                d.cnt    = CW'(1);
                d.addr   = addr;
                d.data   = din;
            end
        end else if (!vpp_prog || !out_en) begin
            d.active = 1'b0;
        end else if (en_strobe) begin
            if (q.cnt <= MAX_V) d.cnt = q.cnt + 1'b1;
            if (q.cnt == MAX_V) d.err = 1'b1;
        end else begin
            d.active = 1'b0;
            if (q.cnt < MIN_V)       d.err = 1'b1;
            else if (q.cnt <= MAX_V) wr_en = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q             <= '0;
            q.strobe_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign wr_addr = q.addr;
    assign wr_data = q.data;
    assign err     = q.err;

    AST_WRITE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (vpp_prog && out_en && !en_strobe)); // R5

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err); // R9

endmodule

// File: rtl/eprom_access.sv
module eprom_access #(
    parameter int ADDR_W  = 11,
    parameter int ACC_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drive,
    input  logic              restart,
    input  logic [ADDR_W-1:0] addr,
    output logic              dvalid
);

    localparam int            CW    = $clog2(ACC_CYC + 1);
    localparam logic [CW-1:0] ACC_V = CW'(ACC_CYC);

    typedef struct packed {
        logic [CW-1:0]     cnt;
        logic [ADDR_W-1:0] last_addr;
        logic              was_drv;
    } acc_t;

    acc_t q, d;
    logic stable;

    always_comb begin
        stable      = q.was_drv && (addr == q.last_addr);
        d           = q;
        d.last_addr = addr;
        d.was_drv   = drive;
        if (!drive || restart) d.cnt = '0;
        else if (!stable)      d.cnt = CW'(1);
        else if (q.cnt < ACC_V) d.cnt = q.cnt + 1'b1;
        dvalid = drive && stable && (q.cnt == ACC_V);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_VALID_NEEDS_HISTORY: assert property (@(posedge clk) disable iff (!rst_n)
        dvalid |-> ($past(drive) && ($past(addr) == addr))); // R10

    AST_RESTART_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !dvalid); // R11

endmodule

// File: rtl/eprom_model.sv
module eprom_model #(
    parameter int ADDR_W    = 11,
    parameter int DATA_W    = 8,
    parameter int ACC_CYC   = 3,
    parameter int PULSE_MIN = 4,
    parameter int PULSE_MAX = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              en_strobe,
    input  logic              out_en,
    input  logic              vpp_prog,
    input  logic              vpp_gnd,
    input  logic              erase,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dq_oe,
    output logic              dvalid,
    output logic              pulse_err
);

    logic              drive;
    logic              wipe;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;

    assign wipe = erase || !rst_n;

    eprom_mode_dec u_dec (
        .en_strobe (en_strobe),
        .out_en    (out_en),
        .vpp_prog  (vpp_prog),
        .vpp_gnd   (vpp_gnd),
        .drive     (drive)
    );

    eprom_pulse #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .PULSE_MIN (PULSE_MIN),
        .PULSE_MAX (PULSE_MAX)
    ) u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_strobe (en_strobe),
        .out_en    (out_en),
        .vpp_prog  (vpp_prog),
        .addr      (addr),
        .din       (din),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .err       (pulse_err)
    );

    eprom_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wipe    (wipe),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (addr),
        .rd_data (rd_data)
    );

    eprom_access #(
        .ADDR_W  (ADDR_W),
        .ACC_CYC (ACC_CYC)
    ) u_access (
        .clk     (clk),
        .rst_n   (rst_n),
        .drive   (drive),
        .restart (wipe),
        .addr    (addr),
        .dvalid  (dvalid)
    );

    assign dq_oe = drive;
    assign dout  = dvalid ? rd_data : '0;

    AST_STANDBY_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        (!vpp_prog && en_strobe) |-> (!dq_oe && !dvalid)); // R3

    AST_INHIBIT_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        (vpp_prog && !en_strobe && out_en) |-> !dq_oe); // R7

endmodule

// File: tb/tb_eprom_model.sv
`timescale 1ns/1ps
module tb_eprom_model;

    localparam int AW   = 11;
    localparam int DW   = 8;
    localparam int ACC  = 3;
    localparam int PMIN = 4;
    localparam int PMAX = 20;
    localparam int NW   = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          en_strobe, out_en, vpp_prog, vpp_gnd, erase;
    logic [DW-1:0] din;
    logic [DW-1:0] dout;
    logic          dq_oe, dvalid, pulse_err;

    always #2.5 clk = ~clk;

    eprom_model #(
        .ADDR_W (AW), .DATA_W (DW), .ACC_CYC (ACC),
        .PULSE_MIN (PMIN), .PULSE_MAX (PMAX)
    ) dut (
        .clk (clk), .rst_n (rst_n), .addr (addr), .en_strobe (en_strobe),
        .out_en (out_en), .vpp_prog (vpp_prog), .vpp_gnd (vpp_gnd),
        .erase (erase), .din (din), .dout (dout), .dq_oe (dq_oe),
        .dvalid (dvalid), .pulse_err (pulse_err)
    );

    // reference model state
    logic [DW-1:0] m_mem [NW];
    int            m_err, m_pact, m_plen, m_paddr, m_pdata, m_sprev;
    int            m_acc, m_last, m_wasdrv;
    int            n_vec = 0;
    int            n_bad = 0;

    function automatic int ref_drive();
        if (vpp_prog) return (!en_strobe && !out_en) ? 1 : 0;
        if (en_strobe) return 0;
        return (vpp_gnd ? out_en : !out_en) ? 1 : 0;
    endfunction

    task automatic compare(input string tag);
        int            e_drv, e_val;
        logic [DW-1:0] e_dout;
        e_drv  = ref_drive();
        e_val  = (e_drv == 1 && m_wasdrv == 1 && m_last == int'(addr) && m_acc == ACC) ? 1 : 0;
        e_dout = (e_val == 1) ? m_mem[addr] : 8'h00;
        n_vec++;
        if (dq_oe !== e_drv[0] || dvalid !== e_val[0] || dout !== e_dout
            || pulse_err !== m_err[0]) begin
            n_bad++;
            $display("FAIL %s addr=%0d: got oe=%b valid=%b dout=%h err=%b, expected oe=%0d valid=%0d dout=%h err=%0d",
                     tag, addr, dq_oe, dvalid, dout, pulse_err, e_drv, e_val, e_dout, m_err);
        end
    endtask

    task automatic model_edge();
        int drv, stable, wr;
        drv = ref_drive();
        if (!rst_n) begin
            for (int i = 0; i < NW; i++) m_mem[i] = 8'hFF;
            m_err = 0; m_pact = 0; m_plen = 0; m_sprev = 1;
            m_acc = 0; m_last = 0; m_wasdrv = 0;
            return;
        end
        wr = 0;
        if (m_pact == 0) begin
            if (vpp_prog && out_en && en_strobe && m_sprev == 0) begin
                m_pact = 1; m_plen = 1; m_paddr = int'(addr); m_pdata = int'(din);
            end
        end else if (!vpp_prog || !out_en) begin
            m_pact = 0;
        end else if (en_strobe) begin
            m_plen++;
            if (m_plen > PMAX) m_err = 1;
        end else begin
            m_pact = 0;
            if (m_plen < PMIN) m_err = 1;
            else if (m_plen <= PMAX) wr = 1;
        end
        m_sprev = en_strobe ? 1 : 0;
        if (erase) begin
            for (int i = 0; i < NW; i++) m_mem[i] = 8'hFF;
        end else if (wr == 1) begin
            m_mem[m_paddr] = m_mem[m_paddr] & m_pdata[DW-1:0];
        end
        stable = (m_wasdrv == 1 && m_last == int'(addr)) ? 1 : 0;
        if (drv == 0 || erase) m_acc = 0;
        else if (stable == 0)  m_acc = 1;
        else if (m_acc < ACC)  m_acc++;
        m_wasdrv = drv;
        m_last   = int'(addr);
    endtask

    task automatic cyc(input string tag, input int n = 1);
        for (int k = 0; k < n; k++) begin
            #1;
            if (rst_n) compare(tag);
            @(posedge clk);
            model_edge();
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cyc("RST", 2);
        rst_n = 1'b1;
    endtask

    task automatic pulse(input int a, input int dat, input int len, input string tag);
        vpp_prog = 1'b1; out_en = 1'b1; en_strobe = 1'b0;
        addr = AW'(a); din = DW'(dat);
        cyc(tag, 1);
        en_strobe = 1'b1;
        cyc(tag, len);
        en_strobe = 1'b0;
        cyc(tag, 2);
    endtask

    task automatic verify(input int a, input string tag);
        vpp_prog = 1'b1; en_strobe = 1'b0; out_en = 1'b0; addr = AW'(a);
        cyc(tag, ACC + 2);
    endtask

    initial begin
        #(5.0 * 100000);
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; addr = '0; en_strobe = 1'b1; out_en = 1'b0;
        vpp_prog = 1'b0; vpp_gnd = 1'b0; erase = 1'b0; din = '0;
        @(negedge clk);
        cyc("R3", 3);
        rst_n = 1'b1;
        cyc("R3", 2);                       // reset state: standby, no error
        out_en = 1'b1; cyc("R3", 2);        // standby ignores out_en

        // R1 / R10: reads of erased array, latency, address change
        en_strobe = 1'b0; out_en = 1'b0; addr = 11'd5;
        cyc("R10", ACC + 3);
        addr = 11'd2047; cyc("R1", ACC + 2);
        addr = 11'd0;    cyc("R1", ACC + 2);
        addr = 11'd7; cyc("R10", 1); addr = 11'd8; cyc("R10", ACC + 2);

        // R4: output disable and polarity swap
        out_en = 1'b1; cyc("R4", 3);
        vpp_gnd = 1'b1; cyc("R4", ACC + 2);
        out_en = 1'b0; cyc("R4", 2);
        vpp_gnd = 1'b0;

        // R7 inhibit, R5 program, R6 verify
        vpp_prog = 1'b1; out_en = 1'b1; addr = 11'd5; din = 8'hA5;
        cyc("R7", 3);
        pulse(5, 8'hA5, 6, "R5");
        verify(5, "R6");
        // R2: clear-only accumulation
        pulse(5, 8'h5A, 6, "R2");
        verify(5, "R2");
        pulse(6, 8'hF0, 5, "R2");
        pulse(6, 8'h3C, 5, "R2");
        verify(6, "R2");
        // R5 boundaries: exactly PMIN and exactly PMAX
        pulse(3, 8'h11, PMIN, "R5");
        pulse(4, 8'h22, PMAX, "R5");
        verify(3, "R5"); verify(4, "R5");

        // R8: short pulse
        pulse(9, 8'h00, PMIN - 1, "R8");
        verify(9, "R8");

        // R9: long pulse, sticky flag
        do_reset();
        pulse(10, 8'h00, PMAX + 3, "R9");
        verify(10, "R9");
        pulse(14, 8'h0F, 6, "R9");
        verify(14, "R9");

        // R12: aborted pulses
        do_reset();
        vpp_prog = 1'b1; out_en = 1'b1; en_strobe = 1'b0; addr = 11'd11; din = 8'h00;
        cyc("R12", 1);
        en_strobe = 1'b1; cyc("R12", 5);
        out_en = 1'b0; cyc("R12", 1);
        en_strobe = 1'b0; cyc("R12", 2);
        verify(11, "R12");
        out_en = 1'b1; addr = 11'd15; cyc("R12", 1);
        en_strobe = 1'b1; cyc("R12", 5);
        vpp_prog = 1'b0; cyc("R12", 1);
        en_strobe = 1'b0; vpp_prog = 1'b1; cyc("R12", 2);
        verify(15, "R12");

        // R7: strobe rises while out_en low
        out_en = 1'b0; addr = 11'd13; cyc("R7", 1);
        en_strobe = 1'b1; cyc("R7", 2);
        out_en = 1'b1; cyc("R7", 6);
        en_strobe = 1'b0; cyc("R7", 2);
        verify(13, "R7");

        // R11: erase and write on one edge
        pulse(2, 8'h00, 5, "R11");
        vpp_prog = 1'b1; out_en = 1'b1; addr = 11'd12; din = 8'h00;
        cyc("R11", 1);
        en_strobe = 1'b1; cyc("R11", 6);
        en_strobe = 1'b0; erase = 1'b1; cyc("R11", 1);
        erase = 1'b0; cyc("R11", 1);
        verify(12, "R11"); verify(2, "R11");
        // R11: erase during a steady read restarts latency
        pulse(20, 8'h81, 5, "R11");
        vpp_prog = 1'b0; en_strobe = 1'b0; out_en = 1'b0; addr = 11'd20;
        cyc("R11", ACC + 2);
        erase = 1'b1; cyc("R11", 1);
        erase = 1'b0; cyc("R11", ACC + 2);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule